// File: doc/BRIEF.md
# SAR Converter Control Sequencer

This block is the digital control core of a multi-channel successive-approximation converter with a byte-wide host bus. The host writes an 8-bit control word on the rising edge of an active-low write strobe while chip-select is low. That word chooses the power state and conversion clock source, the acquisition style, the input configuration and the channel. The block then runs the acquisition phase and a fixed 13-tick conversion. In that conversion a one-hot trial pointer walks from MSB to LSB, and the analog comparator's decision on each trial is fed back through `cmp_in`. When the result is ready the block pulls its interrupt low. The host reads the 10-bit result as two bytes, chosen by a high-byte select.

All host pins (`cs_n`, `wr_n`, `rd_n`, `conv_clk`) are sampled by the system clock `clk`, and their edges are detected in that domain. In internal-clock mode, conversion ticks come from a divider on `clk`. In external-clock mode, each falling edge of `conv_clk` seen while chip-select is low is one tick. `hold` tells the analog front end when the sample is frozen. `dac_code` is the trial word for the capacitive DAC.

Top module: `sar_adc_sequencer`

## Requirements
- R1: A control word is taken from `din` only on a rising edge of `wr_n` while `cs_n` is low. Its fields are: bits 7:6 power/clock code; bit 5 acquisition style (1 = host-timed); bit 4 input type (1 = single-ended, shown on `mux_se`); bit 3 format (1 = unipolar); bits 2:0 channel (shown on `mux_addr`).
- R2: The power/clock code works as follows. 11 selects normal operation with the external clock. 10 selects normal operation with the internal clock (`clk_int` = 1). 01 selects standby and 00 selects shutdown. Both power-down codes leave `clk_int` unchanged.
- R3: With bit 5 = 0, `hold` rises on the 4th conversion-clock tick after the write.
- R4: With bit 5 = 1, acquisition stays open (`hold` low) for any number of ticks. A following write with bit 5 = 0 raises `hold` at once.
- R5: If the channel field of that second write differs from the first, `addr_err` is 1 until the next write. Otherwise it is 0.
- R6: A conversion lasts 13 ticks. `int_n` falls on the 13th tick after `hold` rose, and `hold` drops at the same moment.
- R7: The result is the largest code whose trial the comparator accepted, found MSB first. In unipolar mode it is straight binary. In bipolar mode its MSB is inverted, which gives two's complement.
- R8: `int_n` returns high on the first falling edge of `rd_n` with `cs_n` low, or on any accepted write.
- R9: With `hben` = 0, `dout` carries result bits 7:0. With `hben` = 1, `dout[1:0]` carries bits 9:8, and `dout[7:2]` is zero in unipolar mode or copies of bit 9 in bipolar mode.
- R10: While `cs_n` is high, `dout_oe` and `int_oe` are 0, and activity on `wr_n`, `rd_n` and `conv_clk` has no effect.
- R11: A write during acquisition or conversion aborts it: `hold` goes low and the new word's acquisition begins.
- R12: In standby or shutdown, no conversion starts and `hold` stays low. The next write with a normal code clears both flags and resumes conversions.
- R13: After reset, the external clock is selected, the power flags are clear, `hold` is low and `int_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| hben | input | 1 | Result byte select (1 = high byte) |
| conv_clk | input | 1 | External conversion clock |
| din | input | 8 | Control word from host bus |
| cmp_in | input | 1 | Comparator decision (1 = input at or above trial) |
| dout | output | 8 | Result byte to host bus |
| dout_oe | output | 1 | Bus drive enable |
| int_n | output | 1 | Active-low result-ready flag |
| int_oe | output | 1 | Drive enable for `int_n` |
| hold | output | 1 | Sample held, conversion running |
| dac_code | output | 10 | Current trial word for the DAC |
| mux_addr | output | 3 | Selected channel field |
| mux_se | output | 1 | Single-ended input selected |
| clk_int | output | 1 | Internal conversion clock selected |
| standby | output | 1 | Standby power-down active |
| shutdown | output | 1 | Full shutdown active |
| addr_err | output | 1 | Channel changed between the two host-timed writes |

## Verification
A wrong sequencer state first shows on `hold`. A count that is off by one moves the rising edge of `hold` or the falling edge of `int_n` by a whole conversion-clock tick, so the bench counts every external falling edge it drives and samples right after the 3rd/4th and 12th/13th. A damaged trial pointer or format bit shows only when the result is read, one conversion later, as a wrong byte under one of the two `hben` settings. Stale power or clock state shows on the flag outputs in the cycle after the write that should have changed it.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_ACQ_INT = 2'd1,
    SQ_ACQ_EXT = 2'd2,
    SQ_CONV    = 2'd3
  } seq_state_e;

  // Host control word, MSB first
  typedef struct packed {
    logic [1:0] pwr;       // 11 ext clk, 10 int clk, 01 standby, 00 shutdown
    logic       acq_ext;   // host-timed acquisition
    logic       single;    // single-ended input
    logic       unipolar;  // straight binary result
    logic [2:0] addr;      // channel
  } ctrl_word_t;

endpackage

// File: rtl/sar_seq_strobes.sv
module sar_seq_strobes (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  input  logic rd_n,
  input  logic conv_clk,
  output logic wr_evt,
  output logic rd_evt,
  output logic ext_fall
);

  logic wr_q, rd_q, cc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
      cc_q <= 1'b0;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
      cc_q <= conv_clk;
    end
  end

  // all host edges are qualified by an active chip select
  assign wr_evt   = ~cs_n & ~wr_q & wr_n;
  assign rd_evt   = ~cs_n & rd_q & ~rd_n;
  assign ext_fall = ~cs_n & cc_q & ~conv_clk;

endmodule

// File: rtl/sar_seq_tick.sv
module sar_seq_tick #(
  parameter int INT_DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_mode,
  input  logic ext_fall,
  output logic tick
);

  generate
    if (INT_DIV <= 1) begin : g_nodiv
      assign tick = int_mode | ext_fall;
    end else begin : g_div
      localparam int DIV_W = $clog2(INT_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);
      logic [DIV_W-1:0] cnt_q, cnt_d;
      logic             wrap;

      assign wrap = (cnt_q == DIV_LAST);

      always_comb begin
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = int_mode ? wrap : ext_fall;
    end
  endgenerate

endmodule

// File: rtl/sar_seq_sar.sv
module sar_seq_sar #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         cmp,
  output logic [N-1:0] trial,
  output logic [N-1:0] result
);

  logic [N-1:0] ptr_q, ptr_d;
  logic [N-1:0] acc_q, acc_d;

  always_comb begin
    ptr_d = ptr_q;
    acc_d = acc_q;
    if (clear) begin
      ptr_d = {1'b1, {(N-1){1'b0}}};
      acc_d = '0;
    end else if (step) begin
      if (cmp) acc_d = acc_q | ptr_q;
      ptr_d = ptr_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      acc_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      acc_q <= acc_d;
    end
  end

  assign trial  = acc_q | ptr_q;
  assign result = acc_q;

endmodule

// File: rtl/sar_seq_outfmt.sv
module sar_seq_outfmt #(
  parameter int RES = 10,
  parameter int BUS = 8
) (
  input  logic [RES-1:0] res,
  input  logic           bip,
  input  logic           hben,
  input  logic           cs_n,
  input  logic           rd_n,
  output logic [BUS-1:0] dout,
  output logic           dout_oe,
  output logic           int_oe
);

  localparam int HI = RES - BUS;

  logic [BUS-1:0] hi_byte;

  assign hi_byte = {{(BUS-HI){bip & res[RES-1]}}, res[RES-1:BUS]};
  assign dout    = hben ? hi_byte : res[BUS-1:0];
  assign dout_oe = ~cs_n & ~rd_n;
  assign int_oe  = ~cs_n;

endmodule

// File: rtl/sar_adc_sequencer.sv
module sar_adc_sequencer #(
  parameter int RES_BITS   = 10,
  parameter int BUS_BITS   = 8,
  parameter int ACQ_TICKS  = 4,
  parameter int CONV_TICKS = 13,
  parameter int INT_DIV    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                wr_n,
  input  logic                rd_n,
  input  logic                hben,
  input  logic                conv_clk,
  input  logic [7:0]          din,
  input  logic                cmp_in,
  output logic [BUS_BITS-1:0] dout,
  output logic                dout_oe,
  output logic                int_n,
  output logic                int_oe,
  output logic                hold,
  output logic [RES_BITS-1:0] dac_code,
  output logic [2:0]          mux_addr,
  output logic                mux_se,
  output logic                clk_int,
  output logic                standby,
  output logic                shutdown,
  output logic                addr_err
);
  import sar_seq_pkg::*;

  localparam int CNT_W = $clog2(CONV_TICKS);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_TICKS - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_TICKS - 1);

  logic wr_evt, rd_evt, ext_fall, tick;
  logic sar_clr, sar_step;
  logic [RES_BITS-1:0] sar_res;

  seq_state_e          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [2:0]          maddr_q, maddr_d, eaddr_q, eaddr_d;
  logic                mse_q, mse_d;
  logic                clkint_q, clkint_d;
  logic                stby_q, stby_d, shdn_q, shdn_d;
  logic                int_q, int_d;
  logic [RES_BITS-1:0] res_q, res_d;
  logic                rbip_q, rbip_d, cbip_q, cbip_d;
  logic                aerr_q, aerr_d;
  ctrl_word_t          wb;

  sar_seq_strobes u_strobes (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .conv_clk(conv_clk), .wr_evt(wr_evt), .rd_evt(rd_evt), .ext_fall(ext_fall)
  );

  sar_seq_tick #(.INT_DIV(INT_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .int_mode(clkint_q), .ext_fall(ext_fall), .tick(tick)
  );

  sar_seq_sar #(.N(RES_BITS)) u_sar (
    .clk(clk), .rst_n(rst_n), .clear(sar_clr), .step(sar_step), .cmp(cmp_in),
    .trial(dac_code), .result(sar_res)
  );

  sar_seq_outfmt #(.RES(RES_BITS), .BUS(BUS_BITS)) u_out (
    .res(res_q), .bip(rbip_q), .hben(hben), .cs_n(cs_n), .rd_n(rd_n),
    .dout(dout), .dout_oe(dout_oe), .int_oe(int_oe)
  );

  assign wb = ctrl_word_t'(din);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    maddr_d  = maddr_q;
    mse_d    = mse_q;
    eaddr_d  = eaddr_q;
    clkint_d = clkint_q;
    stby_d   = stby_q;
    shdn_d   = shdn_q;
    int_d    = int_q;
    res_d    = res_q;
    rbip_d   = rbip_q;
    cbip_d   = cbip_q;
    aerr_d   = aerr_q;
    sar_clr  = 1'b0;
    sar_step = 1'b0;

    if (rd_evt) int_d = 1'b1;

    if (wr_evt) begin
      maddr_d = wb.addr;
      mse_d   = wb.single;
      int_d   = 1'b1;
      aerr_d  = 1'b0;
      sar_clr = 1'b1;
      cnt_d   = '0;
      if (!wb.pwr[1]) begin
        // power-down: clock choice retained, sequencer parked
        stby_d  = wb.pwr[0];
        shdn_d  = ~wb.pwr[0];
        state_d = SQ_IDLE;
      end else begin
        stby_d   = 1'b0;
        shdn_d   = 1'b0;
        clkint_d = ~wb.pwr[0];
        if (wb.acq_ext) begin
          state_d = SQ_ACQ_EXT;
          eaddr_d = wb.addr;
        end else if (state_q == SQ_ACQ_EXT) begin
          state_d = SQ_CONV;
          cbip_d  = ~wb.unipolar;
          aerr_d  = (wb.addr != eaddr_q);
        end else begin
          state_d = SQ_ACQ_INT;
          cbip_d  = ~wb.unipolar;
        end
      end
    end else if (tick) begin
      unique case (state_q)
        SQ_ACQ_INT: begin
          if (cnt_q == ACQ_LAST) begin
            state_d = SQ_CONV;
            cnt_d   = '0;
            sar_clr = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SQ_CONV: begin
          sar_step = 1'b1;
          if (cnt_q == CONV_LAST) begin
            state_d = SQ_IDLE;
            cnt_d   = '0;
            int_d   = 1'b0;
            rbip_d  = cbip_q;
            res_d   = {sar_res[RES_BITS-1] ^ cbip_q, sar_res[RES_BITS-2:0]};
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      cnt_q    <= '0;
      maddr_q  <= '0;
      mse_q    <= 1'b0;
      eaddr_q  <= '0;
      clkint_q <= 1'b0;
      stby_q   <= 1'b0;
      shdn_q   <= 1'b0;
      int_q    <= 1'b1;
      res_q    <= '0;
      rbip_q   <= 1'b0;
      cbip_q   <= 1'b0;
      aerr_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      maddr_q  <= maddr_d;
      mse_q    <= mse_d;
      eaddr_q  <= eaddr_d;
      clkint_q <= clkint_d;
      stby_q   <= stby_d;
      shdn_q   <= shdn_d;
      int_q    <= int_d;
      res_q    <= res_d;
      rbip_q   <= rbip_d;
      cbip_q   <= cbip_d;
      aerr_q   <= aerr_d;
    end
  end

  assign hold     = (state_q == SQ_CONV);
  assign int_n    = int_q;
  assign mux_addr = maddr_q;
  assign mux_se   = mse_q;
  assign clk_int  = clkint_q;
  assign standby  = stby_q;
  assign shutdown = shdn_q;
  assign addr_err = aerr_q;

endmodule

// File: rtl/sar_adc_sequencer_chk.sv
module sar_adc_sequencer_chk #(
  parameter int RES = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           wr_n,
  input logic           int_n,
  input logic           int_oe,
  input logic           dout_oe,
  input logic           hold,
  input logic           standby,
  input logic           shutdown,
  input logic           clk_int,
  input logic [RES-1:0] res_q
);

  AST_PD_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (standby || shutdown) |-> !hold);  // R12

  AST_DONE_ENDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> ($past(hold) && !hold));  // R6

  AST_HOLD_START_INT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> int_n);  // R11

  AST_WRITE_CLEARS_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $rose(wr_n)) |=> int_n);  // R8

  AST_CLKMODE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_n && $rose(wr_n)) |=> $stable(clk_int));  // R10

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n && $past(!int_n)) |-> $stable(res_q));  // R9

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!dout_oe && !int_oe));  // R10

endmodule

bind sar_adc_sequencer sar_adc_sequencer_chk #(.RES(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .int_n(int_n),
  .int_oe(int_oe), .dout_oe(dout_oe), .hold(hold), .standby(standby),
  .shutdown(shutdown), .clk_int(clk_int), .res_q(res_q)
);

// File: tb/sar_adc_sequencer_test.sv
`timescale 1ns/1ps
module sar_adc_sequencer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, hben = 1'b0, conv_clk = 1'b0;
  logic [7:0] din = 8'h00;
  logic       cmp_in;
  logic [7:0] dout;
  logic       dout_oe, int_n, int_oe, hold, mux_se, clk_int, standby, shutdown, addr_err;
  logic [9:0] dac_code;
  logic [2:0] mux_addr;
  logic [9:0] vin = 10'h000;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  // behavioural comparator: accepts a trial not above the held input
  assign cmp_in = (dac_code <= vin);

  sar_adc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .hben(hben),
    .conv_clk(conv_clk), .din(din), .cmp_in(cmp_in), .dout(dout), .dout_oe(dout_oe),
    .int_n(int_n), .int_oe(int_oe), .hold(hold), .dac_code(dac_code),
    .mux_addr(mux_addr), .mux_se(mux_se), .clk_int(clk_int), .standby(standby),
    .shutdown(shutdown), .addr_err(addr_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] fmt(input logic [9:0] v, input logic uni);
    return uni ? v : (v ^ 10'h200);
  endfunction

  function automatic logic [7:0] byte_of(input logic [9:0] r, input logic uni, input logic hb);
    if (!hb) return r[7:0];
    return {{6{~uni & r[9]}}, r[9:8]};
  endfunction

  task automatic wr(input logic [7:0] b);
    @(negedge clk); din = b; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfall(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); conv_clk = 1'b1;
      @(negedge clk); conv_clk = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic rd(input logic hb, output logic [7:0] d, output logic oe);
    @(negedge clk); hben = hb; rd_n = 1'b0;
    @(negedge clk); d = dout; oe = dout_oe; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_result(input string req, input logic [9:0] v, input logic uni);
    logic [7:0] d;
    logic oe;
    logic [9:0] r;
    r = fmt(v, uni);
    rd(1'b0, d, oe);
    chk(req, "low byte", d, byte_of(r, uni, 1'b0));
    chk("R10", "bus enabled on read", oe, 1'b1);
    chk("R8", "int high after read", int_n, 1'b1);
    rd(1'b1, d, oe);
    chk("R9", "high byte", d, byte_of(r, uni, 1'b1));
  endtask

  // full external-clock conversion with tick-exact checks
  task automatic run_conv(input logic acq_ext, input logic se, input logic uni,
                          input logic [2:0] addr, input logic [9:0] v);
    vin = v;
    if (acq_ext) begin
      wr({2'b11, 1'b1, se, uni, addr});
      cfall(3);
      chk("R4", "hold open acquisition", hold, 1'b0);
      wr({2'b11, 1'b0, se, uni, addr});
      chk("R4", "hold at second write", hold, 1'b1);
      chk("R5", "no addr error", addr_err, 1'b0);
    end else begin
      wr({2'b11, 1'b0, se, uni, addr});
      chk("R1", "mux addr", mux_addr, addr);
      chk("R1", "mux se", mux_se, se);
      cfall(3);
      chk("R3", "hold after 3 ticks", hold, 1'b0);
      cfall(1);
      chk("R3", "hold after 4 ticks", hold, 1'b1);
    end
    cfall(12);
    chk("R6", "int after 12 ticks", int_n, 1'b1);
    cfall(1);
    chk("R6", "int after 13 ticks", int_n, 1'b0);
    chk("R6", "hold dropped", hold, 1'b0);
    check_result("R7", v, uni);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic oe;
    int unsigned seed;
    bit got;
    seed = $urandom(32'd2024);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state, R10 deselected outputs
    chk("R13", "clk_int", clk_int, 1'b0);
    chk("R13", "standby", standby, 1'b0);
    chk("R13", "shutdown", shutdown, 1'b0);
    chk("R13", "hold", hold, 1'b0);
    chk("R10", "int_oe deselected", int_oe, 1'b0);
    chk("R10", "dout_oe deselected", dout_oe, 1'b0);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R13", "int_n", int_n, 1'b1);
    chk("R10", "int_oe selected", int_oe, 1'b1);

    // directed: internal acquisition, unipolar, extremes
    run_conv(1'b0, 1'b1, 1'b1, 3'd5, 10'h2A5);
    run_conv(1'b0, 1'b0, 1'b1, 3'd2, 10'h3FF);
    // host-timed acquisition, bipolar
    run_conv(1'b1, 1'b1, 1'b0, 3'd3, 10'h155);
    run_conv(1'b1, 1'b1, 1'b0, 3'd3, 10'h2AA);
    run_conv(1'b0, 1'b1, 1'b0, 3'd0, 10'h000);

    // R4 long open acquisition then R5 channel mismatch
    vin = 10'h0F0;
    wr(8'hE1);
    cfall(40);
    chk("R4", "hold stays low", hold, 1'b0);
    wr(8'hC6);
    chk("R5", "addr mismatch flagged", addr_err, 1'b1);
    chk("R4", "hold at second write", hold, 1'b1);
    cfall(13);
    chk("R6", "int after mismatch conv", int_n, 1'b0);
    wr(8'hD8);
    chk("R5", "flag cleared by write", addr_err, 1'b0);
    chk("R8", "write clears int", int_n, 1'b1);

    // R11 abort mid-conversion
    vin = 10'h111;
    cfall(4);
    chk("R11", "hold before abort", hold, 1'b1);
    cfall(5);
    wr(8'hD9);
    chk("R11", "hold dropped on abort", hold, 1'b0);
    chk("R11", "int high on abort", int_n, 1'b1);
    vin = 10'h1C3;
    cfall(3);
    chk("R11", "new acquisition timing", hold, 1'b0);
    cfall(1);
    chk("R11", "new hold", hold, 1'b1);
    cfall(13);
    chk("R11", "aborted run completes", int_n, 1'b0);
    check_result("R11", 10'h1C3, 1'b1);

    // R2 internal clock, then power-down retains it
    vin = 10'h2D2;
    wr(8'h98);
    chk("R2", "internal clock selected", clk_int, 1'b1);
    got = 1'b0;
    for (int i = 0; i < 2000 && !got; i++) begin
      @(negedge clk);
      if (!int_n) got = 1'b1;
    end
    chk("R2", "internal clock conversion done", got, 1'b1);
    check_result("R7", 10'h2D2, 1'b1);
    wr(8'h18);
    chk("R2", "shutdown flag", shutdown, 1'b1);
    chk("R2", "clock kept in shutdown", clk_int, 1'b1);
    got = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (hold || !int_n) got = 1'b1;
    end
    chk("R12", "no conversion in shutdown", got, 1'b0);
    wr(8'h58);
    chk("R2", "standby flag", standby, 1'b1);
    chk("R2", "shutdown cleared", shutdown, 1'b0);
    chk("R2", "clock kept in standby", clk_int, 1'b1);
    cfall(20);
    chk("R12", "no hold in standby", hold, 1'b0);
    rd(1'b0, d, oe);
    chk("R12", "bus active in standby", oe, 1'b1);
    chk("R12", "standby read keeps result", d, 8'hD2);
    run_conv(1'b0, 1'b1, 1'b1, 3'd1, 10'h07E);
    chk("R12", "standby left", standby, 1'b0);
    chk("R2", "external clock back", clk_int, 1'b0);

    // R10 deselected activity ignored (result pending)
    vin = 10'h3A1;
    wr(8'hDC);
    cfall(17);
    chk("R10", "pending result", int_n, 1'b0);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk("R10", "dout_oe off when deselected", dout_oe, 1'b0);
    chk("R10", "int_oe off when deselected", int_oe, 1'b0);
    rd_n = 1'b1;
    @(negedge clk); din = 8'h18; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); conv_clk = 1'b1;
      @(negedge clk); conv_clk = 1'b0;
    end
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    chk("R10", "int unchanged", int_n, 1'b0);
    chk("R10", "no shutdown from ignored write", shutdown, 1'b0);
    check_result("R10", 10'h3A1, 1'b1);

    // constrained random conversions
    for (int k = 0; k < 24; k++) begin
      logic [31:0] r;
      r = $urandom;
      run_conv(r[0], r[1], r[2], r[5:3], r[15:6]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule